// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block turns level-sensitive interrupt input lines into address/data message writes. Each line owns two words in an internal register file. The control word holds a mask bit, some trigger attributes and a 6-bit vector. The destination word holds a message target address in a byte-swapped ("swizzled") layout. When a line is asserted and not masked, the block marks it in service and issues exactly one message write. The message carries the decoded destination address and the line's vector.

Software reaches the register file indirectly through a 64-bit register bus. It first writes an index into a select register, then reads or writes the chosen word through a window register that sits one word above it. A third bus word acts as the end-of-interrupt (EOI) port. Writing a vector there retires every in-service line that uses that vector. A line that is still asserted after its EOI is delivered again. Only one message is in flight at a time, and waiting lines are served in fixed priority order.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: Synchronous reset clears the select register, all in-service state and `msg_valid`. Each control word of line n resets to 0x1A000 + n + 2: mask bit 16 set, level bit 15 set, active-low bit 13 set, vector n+2. Each destination word resets to 0xA0FF0000, the swizzled form of the default address 0xFFFA0000.
- R2: Bus byte offset 0x00 is the select register, which reads back its 8-bit value. Offset 0x08 is the window onto word `select`. A read strobe returns data on `bus_rdata`, with `bus_rvalid` high, in the following cycle.
- R3: A window read while select is 1 returns the version word 0x0000_0000_0020_0001: 32 entries in bits 31:16 and 1 in the low field.
- R4: When select is 32 or more, window reads return all ones and window writes change no word of the register file.
- R5: Line n uses word 16+2n as its control word, with the mask in bit 16 and the vector in bits 5:0. It uses word 17+2n as its destination word.
- R6: When line n is high and its mask bit is clear, the line enters service and exactly one message write is issued with `msg_data` equal to its vector. No further message follows while the line stays high and in service.
- R7: Deasserting a line, or setting its mask bit, takes it out of service. A message that has not yet been issued for it is dropped. A later unmasked assertion produces a new message.
- R8: The message address is built from the stored destination word s as {4'hF, s[23:16], s[31:24], 12'h000}. Because the top nibble is forced to ones, the address is never zero.
- R9: A bus write to offset 0x10 takes the low 6 bits of the data as a vector. It takes every line whose control vector equals that value out of service. Any such line that is still asserted and unmasked is delivered again.
- R10: At most one message is outstanding. `msg_addr` and `msg_data` hold steady until `msg_ready` is seen. Lines that are waiting are issued lowest line number first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register bus write strobe |
| bus_rd | input | 1 | Register bus read strobe |
| bus_addr | input | ADDR_W (5) | Byte offset of the bus word |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid one cycle after `bus_rd` |
| bus_rvalid | output | 1 | Marks the cycle that `bus_rdata` is valid |
| irq_in | input | NUM_LINES (8) | Interrupt input levels, high means asserted |
| msg_valid | output | 1 | A message write is offered |
| msg_ready | input | 1 | The receiver accepts the offered message |
| msg_addr | output | 32 | Decoded destination address |
| msg_data | output | 6 | Vector of the line being delivered |

## Verification
The assertions take several things for granted about the inputs. Reset must be held for at least one clock before any activity. `irq_in`, `msg_ready` and the bus strobes must change only between clock edges. `msg_ready` must be a plain level that may stay low for any number of cycles. The bench drives every input on the falling edge and never raises a read and a write together. It holds `msg_ready` low while several lines contend, so that ordering and hold behaviour are visible. It also masks or drops lines both before and after their message has been accepted.

// File: rtl/irc_pkg.sv
package irc_pkg;

  localparam int DATA_W     = 64;
  localparam int MSG_AW     = 32;
  localparam int VEC_W      = 6;
  localparam int MASK_BIT   = 16;
  localparam int LEVEL_BIT  = 15;
  localparam int POL_BIT    = 13;
  localparam int LOWPRI_BIT = 8;
  localparam int VEC_OFFSET = 2;
  localparam int VER_IDX    = 1;

  // masked, level triggered, active low
  localparam logic [31:0] CTRL_RESET_BITS =
    (32'd1 << MASK_BIT) | (32'd1 << LEVEL_BIT) | (32'd1 << POL_BIT);

  typedef struct packed {
    logic [MSG_AW-1:0] addr;
    logic [VEC_W-1:0]  vec;
  } msg_t;

  // stored upper half {a[19:12], a[27:20]} -> full target address
  function automatic logic [MSG_AW-1:0] dest_decode(input logic [15:0] sw);
    return {4'hF, sw[7:0], sw[15:8], 12'h000};
  endfunction

  // address bits 27:12 -> stored upper half
  function automatic logic [15:0] dest_encode(input logic [15:0] mid);
    return {mid[7:0], mid[15:8]};
  endfunction

endpackage

// File: rtl/irc_regfile.sv
module irc_regfile
  import irc_pkg::*;
#(
  parameter int          NUM_LINES    = 8,
  parameter int          REG_WORDS    = 32,
  parameter int          SEL_W        = 8,
  parameter int          ADDR_W       = 5,
  parameter logic [31:0] DEF_CPU_ADDR = 32'hFFFA_0000
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               bus_wr,
  input  logic                               bus_rd,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic [DATA_W-1:0]                  bus_wdata,
  output logic [DATA_W-1:0]                  bus_rdata,
  output logic                               bus_rvalid,
  output logic                               eoi_fire,
  output logic [VEC_W-1:0]                   eoi_vec,
  output logic [NUM_LINES-1:0]               line_mask,
  output logic [NUM_LINES-1:0][VEC_W-1:0]    line_vec,
  output logic [NUM_LINES-1:0][15:0]         line_dest_sw
);

  localparam int IDX_W     = $clog2(REG_WORDS);
  localparam int OFF_W     = ADDR_W - 3;
  localparam int LINE_BASE = REG_WORDS / 2;
  localparam logic [31:0] VERSION = {16'(REG_WORDS), 16'h0001};
  localparam logic [OFF_W-1:0] OFF_SEL = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_WIN = OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_EOI = OFF_W'(2);

  logic [DATA_W-1:0] words [REG_WORDS];
  logic [SEL_W-1:0]  sel_q;
  logic [OFF_W-1:0]  word_off;
  logic              is_sel, is_win, is_eoi, sel_ok;
  logic [IDX_W-1:0]  sel_idx;

  assign word_off = bus_addr[ADDR_W-1:3];
  assign is_sel   = (word_off == OFF_SEL);
  assign is_win   = (word_off == OFF_WIN);
  assign is_eoi   = (word_off == OFF_EOI);
  assign sel_ok   = ({1'b0, sel_q} < (SEL_W+1)'(REG_WORDS));
  assign sel_idx  = sel_q[IDX_W-1:0];

  assign eoi_fire = bus_wr && is_eoi;
  assign eoi_vec  = bus_wdata[VEC_W-1:0];

  function automatic logic [DATA_W-1:0] reset_word(input int idx);
    int rel;
    rel = idx - LINE_BASE;
    if (rel < 0 || rel >= 2 * NUM_LINES) return '0;
    if (rel % 2 == 0) return DATA_W'(CTRL_RESET_BITS) | DATA_W'(rel / 2 + VEC_OFFSET);
    return DATA_W'({dest_encode(DEF_CPU_ADDR[27:12]), 16'h0000});
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (bus_wr && is_sel) begin
      sel_q <= bus_wdata[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_WORDS; i++) words[i] <= reset_word(i);
    end else if (bus_wr && is_win && sel_ok) begin
      words[sel_idx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        if (is_sel) begin
          bus_rdata <= DATA_W'(sel_q);
        end else if (is_win) begin
          if (!sel_ok)                           bus_rdata <= '1;
          else if (sel_idx == IDX_W'(VER_IDX))  bus_rdata <= DATA_W'(VERSION);
          else                                   bus_rdata <= words[sel_idx];
        end else begin
          bus_rdata <= '0;
        end
      end
    end
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line_fields
    localparam int CI = LINE_BASE + 2 * n;
    assign line_mask[n]    = words[CI][MASK_BIT];
    assign line_vec[n]     = words[CI][VEC_W-1:0];
    assign line_dest_sw[n] = words[CI+1][31:16];
  end

endmodule

// File: rtl/irc_line.sv
module irc_line
  import irc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             irq,
  input  logic             masked,
  input  logic [VEC_W-1:0] vec,
  input  logic             eoi_fire,
  input  logic [VEC_W-1:0] eoi_vec,
  input  logic             grant,
  output logic             in_svc,
  output logic             req
);

  logic active, eoi_hit, pend;

  assign active  = irq && !masked;
  assign eoi_hit = eoi_fire && (eoi_vec == vec);
  assign req     = pend && active;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_svc <= 1'b0;
      pend   <= 1'b0;
    end else if (!active || eoi_hit) begin
      in_svc <= 1'b0;
      pend   <= 1'b0;
    end else begin
      in_svc <= 1'b1;
      if (!in_svc)    pend <= 1'b1;
      else if (grant) pend <= 1'b0;
    end
  end

endmodule

// File: rtl/irc_msg_port.sv
module irc_msg_port
  import irc_pkg::*;
#(
  parameter int NUM_LINES = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_LINES-1:0]            req,
  input  logic [NUM_LINES-1:0][VEC_W-1:0] line_vec,
  input  logic [NUM_LINES-1:0][15:0]      line_dest_sw,
  input  logic                            msg_ready,
  output logic [NUM_LINES-1:0]            grant,
  output logic                            msg_valid,
  output logic [MSG_AW-1:0]               msg_addr,
  output logic [VEC_W-1:0]                msg_data
);

  logic [NUM_LINES-1:0] pick;
  logic [VEC_W-1:0]     sel_vec;
  logic [15:0]          sel_dest;
  msg_t                 next_msg;

  // isolate lowest requesting line
  assign pick  = req & (~req + NUM_LINES'(1));
  assign grant = msg_valid ? '0 : pick;

  always_comb begin
    sel_vec  = '0;
    sel_dest = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (pick[i]) begin
        sel_vec  = sel_vec  | line_vec[i];
        sel_dest = sel_dest | line_dest_sw[i];
      end
    end
    next_msg.addr = dest_decode(sel_dest);
    next_msg.vec  = sel_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (msg_valid) begin
      if (msg_ready) msg_valid <= 1'b0;
    end else if (|req) begin
      msg_valid <= 1'b1;
      msg_addr  <= next_msg.addr;
      msg_data  <= next_msg.vec;
    end
  end

endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
  import irc_pkg::*;
#(
  parameter int          NUM_LINES    = 8,
  parameter int          REG_WORDS    = 32,
  parameter int          SEL_W        = 8,
  parameter int          ADDR_W       = 5,
  parameter logic [31:0] DEF_CPU_ADDR = 32'hFFFA_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [63:0]          bus_wdata,
  output logic [63:0]          bus_rdata,
  output logic                 bus_rvalid,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [31:0]          msg_addr,
  output logic [5:0]           msg_data
);

  logic                            eoi_fire;
  logic [VEC_W-1:0]                eoi_vec;
  logic [NUM_LINES-1:0]            line_mask;
  logic [NUM_LINES-1:0][VEC_W-1:0] line_vec;
  logic [NUM_LINES-1:0][15:0]      line_dest_sw;
  logic [NUM_LINES-1:0]            line_req;
  logic [NUM_LINES-1:0]            line_isr;
  logic [NUM_LINES-1:0]            line_grant;

  irc_regfile #(
    .NUM_LINES(NUM_LINES), .REG_WORDS(REG_WORDS), .SEL_W(SEL_W),
    .ADDR_W(ADDR_W), .DEF_CPU_ADDR(DEF_CPU_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .eoi_fire(eoi_fire), .eoi_vec(eoi_vec),
    .line_mask(line_mask), .line_vec(line_vec), .line_dest_sw(line_dest_sw)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_lines
    irc_line u_line (
      .clk(clk), .rst(rst),
      .irq(irq_in[n]), .masked(line_mask[n]), .vec(line_vec[n]),
      .eoi_fire(eoi_fire), .eoi_vec(eoi_vec),
      .grant(line_grant[n]), .in_svc(line_isr[n]), .req(line_req[n])
    );
  end

  irc_msg_port #(.NUM_LINES(NUM_LINES)) u_port (
    .clk(clk), .rst(rst),
    .req(line_req), .line_vec(line_vec), .line_dest_sw(line_dest_sw),
    .msg_ready(msg_ready), .grant(line_grant),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
  );

endmodule

// File: rtl/irq_redirect_ctrl_chk.sv
module irq_redirect_ctrl_chk #(
  parameter int NUM_LINES = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_rd,
  input logic                 bus_rvalid,
  input logic [NUM_LINES-1:0] irq_in,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [31:0]          msg_addr,
  input logic [5:0]           msg_data,
  input logic [NUM_LINES-1:0] line_req,
  input logic [NUM_LINES-1:0] line_isr
);

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R2
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid); // R2
  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_ready |=> !msg_valid); // R10
  AST_ADDR_FORM: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_addr[31:28] == 4'hF) && (msg_addr[11:0] == 12'h000)); // R8
  AST_MSG_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> $past(|irq_in)); // R6
  AST_REQ_IN_SERVICE: assert property (@(posedge clk) disable iff (rst)
    (line_req & ~line_isr) == '0); // R6
  AST_REQ_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
    (line_req & ~irq_in) == '0); // R7

endmodule

bind irq_redirect_ctrl irq_redirect_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_rvalid(bus_rvalid),
  .irq_in(irq_in), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data),
  .line_req(line_req), .line_isr(line_isr)
);

// File: tb/irq_redirect_ctrl_tb.sv
module irq_redirect_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NL         = 8;
  localparam logic [4:0] A_SEL = 5'h00;
  localparam logic [4:0] A_WIN = 5'h08;
  localparam logic [4:0] A_EOI = 5'h10;
  localparam logic [31:0] DEF_ADDR = 32'hFFFA_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        bus_rvalid;
  logic [NL-1:0] irq_in = '0;
  logic        msg_valid;
  logic        msg_ready = 1'b1;
  logic [31:0] msg_addr;
  logic [5:0]  msg_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [37:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_redirect_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq_in(irq_in), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic [4:0] a, logic [63:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [63:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R2 rvalid", 64'(bus_rvalid), 64'd1);
    d = bus_rdata;
  endtask

  task automatic win_write(int idx, logic [63:0] d);
    bus_write(A_SEL, 64'(idx));
    bus_write(A_WIN, d);
  endtask

  task automatic win_check(int idx, logic [63:0] exp, string req);
    logic [63:0] d;
    bus_write(A_SEL, 64'(idx));
    bus_read(A_WIN, d);
    check(req, d, exp);
  endtask

  task automatic expect_msg(logic [31:0] a, logic [5:0] v, string req);
    exp_q.push_back({a, v});
    tag_q.push_back(req);
  endtask

  task automatic drain(string req);
    int waited;
    waited = 0;
    while (exp_q.size() != 0 && waited < 300) begin
      @(negedge clk);
      waited++;
    end
    tick(12);
    check(req, 64'(exp_q.size()), 64'd0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // scoreboard monitor: compares each accepted message against the queue
  initial begin : monitor
    logic [37:0] e;
    string t;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (!rst && msg_valid && msg_ready) begin
        if (exp_q.size() == 0) begin
          n_cmp++;
          n_bad++;
          $display("FAIL R6/R7 unexpected message: actual %h expected none", {msg_addr, msg_data});
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, 64'({msg_addr, msg_data}), 64'(e));
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin : stim
    logic [63:0] d;
    tick(5);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    check("R1 msg_valid idle", 64'(msg_valid), 64'd0);
    bus_read(A_SEL, d);
    check("R1 select reset", d, 64'd0);
    for (int n = 0; n < NL; n++) begin
      win_check(16 + 2*n, 64'h1A000 + 64'(n + 2), "R1 R5 control reset");
      win_check(17 + 2*n, 64'h0000_0000_A0FF_0000, "R1 R5 destination reset");
    end

    // R3 version word
    win_check(1, 64'h0000_0000_0020_0001, "R3 version");

    // R2 window write and readback, select readback
    win_write(5, 64'h0123_4567_89AB_CDEF);
    bus_read(A_SEL, d);
    check("R2 select readback", d, 64'd5);
    win_check(5, 64'h0123_4567_89AB_CDEF, "R2 window readback");

    // R4 out-of-range select
    win_check(40, '1, "R4 read all ones");
    win_write(40, 64'h5555_5555_5555_5555);
    win_check(8, 64'd0, "R4 write ignored (word 8)");
    win_check(255, '1, "R4 read all ones at 255");

    // R7 masked line produces nothing
    irq_in[0] = 1'b1;
    tick(10);
    drain("R7 masked line quiet");

    // R6 unmask line 0 while held: one message
    expect_msg(DEF_ADDR, 6'h21, "R6 first delivery");
    win_write(16, 64'h21);
    drain("R6 delivered once");
    tick(20);
    check("R6 no repeat while held", 64'(exp_q.size()), 64'd0);

    // R8 swizzled destination on line 1
    win_write(19, 64'h3C5A_1234);
    win_write(18, 64'h05);
    expect_msg(32'hF5A3_C000, 6'h05, "R8 decoded address");
    irq_in[1] = 1'b1;
    drain("R8 message seen");

    // R9 EOI matching low 6 bits redelivers line 1
    expect_msg(32'hF5A3_C000, 6'h05, "R9 redelivery after EOI");
    bus_write(A_EOI, 64'h45);
    drain("R9 EOI match");
    bus_write(A_EOI, 64'h3F);
    drain("R9 EOI non-matching quiet");

    // R9 shared vector: lines 0 and 2 both retired, R10 order line 0 first
    win_write(21, 64'h3412_0000);
    win_write(20, 64'h21);
    expect_msg(32'hF123_4000, 6'h21, "R6 line 2 delivery");
    irq_in[2] = 1'b1;
    drain("R6 line 2");
    expect_msg(DEF_ADDR, 6'h21, "R9 R10 shared vector line 0");
    expect_msg(32'hF123_4000, 6'h21, "R9 R10 shared vector line 2");
    bus_write(A_EOI, 64'h21);
    drain("R9 shared vector both");

    // R7 deassert then reassert
    irq_in[1] = 1'b0;
    tick(5);
    expect_msg(32'hF5A3_C000, 6'h05, "R7 reassert after drop");
    irq_in[1] = 1'b1;
    drain("R7 deassert clears");

    // R7 mask then unmask while held
    win_write(18, 64'h10005);
    tick(5);
    expect_msg(32'hF5A3_C000, 6'h05, "R7 unmask after mask");
    bus_write(A_WIN, 64'h05);
    drain("R7 mask clears");

    // R10 priority with receiver stalled
    win_write(22, 64'h13);
    win_write(24, 64'h14);
    win_write(26, 64'h15);
    msg_ready = 1'b0;
    irq_in[5:3] = 3'b111;
    tick(6);
    check("R10 held valid", 64'(msg_valid), 64'd1);
    check("R10 lowest line first", 64'(msg_data), 64'h13);
    expect_msg(DEF_ADDR, 6'h13, "R10 order line 3");
    expect_msg(DEF_ADDR, 6'h14, "R10 order line 4");
    expect_msg(DEF_ADDR, 6'h15, "R10 order line 5");
    msg_ready = 1'b1;
    drain("R10 ordering");

    // R7 waiting line masked before issue is dropped
    win_write(28, 64'h16);
    win_write(30, 64'h17);
    msg_ready = 1'b0;
    irq_in[7:6] = 2'b11;
    tick(4);
    win_write(30, 64'h10017);
    expect_msg(DEF_ADDR, 6'h16, "R7 line 6 kept");
    msg_ready = 1'b1;
    drain("R7 pending dropped on mask");
    tick(20);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule